// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block collects interrupt events from client sources and stores each one as a 128-bit vector in a circular buffer in host memory. A write pointer and a read pointer, both counted in bytes, track the buffer. The block advances the write pointer by 16 for every vector it stores. Software consumes vectors and moves the read pointer by writing a register. The ring holds unread vectors whenever the two pointers differ, and it is idle when they match.

Each stored vector raises a one-cycle interrupt pulse. The block can also copy the new write pointer to a writeback location in memory, so software does not need to poll a register for it. If the ring is full and another vector arrives, the block raises an overflow flag. That flag lives in bit 0 of the write-pointer readback, a bit that is otherwise always zero. Memory writes are paced by credits: each request uses one, and each completion returns one.

Register map, selected by the 3-bit address:
- 0: control. The fields are:
  - bit 0: ring enable.
  - bit 1: interrupt enable.
  - bit 2: overflow detection.
  - bit 3: writeback enable.
  - bit 4: re-arm.
  - bit 5: overflow clear. It is a write-only strobe and reads back as 0.
  - bits [12:8]: ring size, given as log2 of the ring length in 32-bit words.
- 1: ring base. This is the memory address shifted right by 8.
- 2: writeback address, low 32 bits.
- 3: writeback address, high 8 bits.
- 4: read pointer.
- 5: write pointer.

Top module: `ivr_writer`

## Requirements
- R1: After reset, the following hold:
  - the control register reads 0x00000E00, meaning a ring of 2^14 words (64 KiB) with every enable bit clear;
  - both pointers read 0;
  - `irq`, `busy` and `mem_req` are low;
  - `ev_ready` is low.
- R2: An accepted event produces one vector write request on the next cycle, with `mem_wb` low. The address is {base, 8'h00} plus the write pointer. The data is laid out as follows:
  - [7:0] holds the source id;
  - [59:32] holds the source data;
  - [71:64] holds the ring id;
  - [79:72] holds the VM id;
  - [95:80] holds the PASID;
  - every other bit is zero.
- R3: Each accepted event advances the write pointer by 16 bytes. The pointer wraps modulo the ring byte size, which is 4 << size. A value written to either pointer register is reduced modulo that size and rounded down to a multiple of 16.
- R4: An overflow occurs when overflow detection is on and an event is accepted while (write pointer + 16) mod size equals the read pointer. On overflow:
  - bit 0 of the write-pointer readback becomes 1;
  - the write pointer still advances;
  - the flag stays set across later events.
  With detection off, the flag never sets.
- R5: Writing the control register with bit 5 set clears the overflow flag. The other control fields are written as usual.
- R6: With writeback enabled, the cycle after a vector request carries a second request:
  - `mem_wb` is high;
  - the address is {high[7:0], low[31:0]};
  - data [31:0] equals the write-pointer readback, including the flag, and the upper bits are zero.
  `ev_ready` is low during the vector-request cycle.
- R7: `irq` pulses for one cycle, together with the last request of an event: the vector request, or the writeback request when writeback is enabled. It pulses only if interrupt enable is set.
- R8: `irq` also pulses in the following case: re-arm and interrupt enable are both set, and a read-pointer write leaves the pointers unequal. A read-pointer write that makes them equal, or any read-pointer write with re-arm clear, gives no pulse.
- R9: With ring enable clear, `ev_ready` stays low. No event is accepted, no request is issued, and the write pointer is unchanged.
- R10: The block holds CREDITS (16) credits. Each request consumes one credit and each `mem_done` pulse returns one. `ev_ready` requires at least 1 free credit, or 2 with writeback enabled. `busy` is high while any credit is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event accepted when high together with ev_valid |
| ev_src | input | 8 | Source id |
| ev_data | input | 28 | Source data |
| ev_ring | input | 8 | Ring id |
| ev_vm | input | 8 | VM id |
| ev_pasid | input | 16 | Process address space id |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory write request, one cycle |
| mem_wb | output | 1 | Request is a pointer writeback, not a vector |
| mem_addr | output | 40 | Byte address of the write |
| mem_data | output | 128 | Write data |
| mem_done | input | 1 | One write completed, returns a credit |
| irq | output | 1 | Interrupt pulse |
| busy | output | 1 | Memory writes outstanding |

## Verification
The hardest state to reach is overflow. The ring must hold exactly one entry fewer than its capacity, with no reads by software, and then another event must arrive. With the default 64 KiB ring that would take thousands of events. The stimulus therefore programs a 4-entry ring, sends three events while the read pointer stays fixed, and expects the fourth and fifth events to set the flag and keep it set. Credit exhaustion is reached by having the memory model withhold completions until all sixteen credits are in use.

// File: rtl/ivr_pkg.sv
package ivr_pkg;

    localparam int ADDR_W = 40;
    localparam int VEC_W  = 128;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_BASE = 3'd1;
    localparam logic [2:0] A_WBLO = 3'd2;
    localparam logic [2:0] A_WBHI = 3'd3;
    localparam logic [2:0] A_RPTR = 3'd4;
    localparam logic [2:0] A_WPTR = 3'd5;

    typedef struct packed {
        logic       ring_en;
        logic       irq_en;
        logic       ovf_det;
        logic       wb_en;
        logic       rearm;
        logic [4:0] log2w;
    } cfg_t;

    typedef enum logic {ST_IDLE, ST_WB} st_e;

endpackage

// File: rtl/ivr_regs.sv
module ivr_regs
    import ivr_pkg::*;
#(
    parameter int DEF_LOG2W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [2:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output cfg_t                cfg,
    output logic [31:0]         base,
    output logic [ADDR_W-1:0]   wb_addr,
    output logic                ovf_clr,
    output logic                rptr_wr,
    output logic                wptr_wr
);

    typedef struct packed {
        cfg_t        cfg;
        logic [31:0] base;
        logic [31:0] wblo;
        logic [7:0]  wbhi;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (reg_wr) begin
            case (reg_addr)
                A_CTRL: begin
                    d.cfg.ring_en = reg_wdata[0];
                    d.cfg.irq_en  = reg_wdata[1];
                    d.cfg.ovf_det = reg_wdata[2];
                    d.cfg.wb_en   = reg_wdata[3];
                    d.cfg.rearm   = reg_wdata[4];
                    d.cfg.log2w   = reg_wdata[12:8];
                end
                A_BASE:  d.base = reg_wdata;
                A_WBLO:  d.wblo = reg_wdata;
                A_WBHI:  d.wbhi = reg_wdata[7:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.cfg.log2w <= 5'(DEF_LOG2W);
        end else begin
            q <= d;
        end
    end

    assign cfg     = q.cfg;
    assign base    = q.base;
    assign wb_addr = {q.wbhi, q.wblo};
    assign ovf_clr = reg_wr && (reg_addr == A_CTRL) && reg_wdata[5];
    assign rptr_wr = reg_wr && (reg_addr == A_RPTR);
    assign wptr_wr = reg_wr && (reg_addr == A_WPTR);

endmodule

// File: rtl/ivr_ring.sv
module ivr_ring
    import ivr_pkg::*;
#(
    parameter int MAX_LOG2W = 14,
    parameter int PTR_W     = MAX_LOG2W + 2,
    parameter int CREDITS   = 16,
    parameter int CRED_W    = $clog2(CREDITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  cfg_t                cfg,
    input  logic [31:0]         base,
    input  logic [ADDR_W-1:0]   wb_addr,
    input  logic                ovf_clr,
    input  logic                rptr_wr,
    input  logic                wptr_wr,
    input  logic [PTR_W-1:0]    ptr_wdata,
    input  logic                ev_valid,
    input  logic [VEC_W-1:0]    vec,
    input  logic                mem_done,
    output logic                ev_ready,
    output logic                mem_req,
    output logic                mem_wb,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [VEC_W-1:0]    mem_data,
    output logic                irq,
    output logic                busy,
    output logic [PTR_W-1:0]    rptr,
    output logic [PTR_W-1:0]    wptr,
    output logic                ovf,
    output logic [CRED_W-1:0]   cred
);

    typedef struct packed {
        st_e               st;
        logic [PTR_W-1:0]  rptr;
        logic [PTR_W-1:0]  wptr;
        logic              ovf;
        logic [CRED_W-1:0] cred;
        logic              req;
        logic              wb;
        logic              irq;
        logic [ADDR_W-1:0] addr;
        logic [VEC_W-1:0]  data;
    } ring_t;

    ring_t q, d;

    logic [4:0]        sz;
    logic [PTR_W:0]    span;
    logic [PTR_W-1:0]  mask;
    logic [PTR_W-1:0]  adv;
    logic [PTR_W-1:0]  pv;
    logic [CRED_W-1:0] need;
    logic [31:0]       wp_word;
    logic              take;

    always_comb begin
        sz      = (cfg.log2w > 5'(MAX_LOG2W)) ? 5'(MAX_LOG2W) : cfg.log2w;
        span    = (PTR_W + 1)'(4) << sz;
        mask    = PTR_W'(span - 1'b1);
        adv     = (q.wptr + PTR_W'(16)) & mask;
        pv      = ptr_wdata & mask & ~PTR_W'(15);
        need    = cfg.wb_en ? CRED_W'(2) : CRED_W'(1);
        wp_word = 32'(q.wptr) | 32'(q.ovf);
        ev_ready = cfg.ring_en && (q.st == ST_IDLE) && (q.cred >= need);
        take     = ev_valid && ev_ready;

        d     = q;
        d.req = 1'b0;
        d.wb  = 1'b0;
        d.irq = 1'b0;
        d.ovf = q.ovf & ~ovf_clr;

        if (take) begin
            d.req  = 1'b1;
            d.addr = {base, 8'h00} + ADDR_W'(q.wptr);
            d.data = vec;
            d.wptr = adv;
            if (cfg.ovf_det && (adv == q.rptr)) d.ovf = 1'b1;
            if (cfg.wb_en) d.st = ST_WB;
            else           d.irq = cfg.irq_en;
        end else if (q.st == ST_WB) begin
            d.req  = 1'b1;
            d.wb   = 1'b1;
            d.addr = wb_addr;
            d.data = {96'h0, wp_word};
            d.st   = ST_IDLE;
            d.irq  = cfg.irq_en;
        end

        if (wptr_wr) d.wptr = pv;
        if (rptr_wr) begin
            d.rptr = pv;
            if (cfg.rearm && cfg.irq_en && (pv != d.wptr)) d.irq = 1'b1;
        end

        d.cred = q.cred - CRED_W'(d.req) + CRED_W'(mem_done);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.cred <= CRED_W'(CREDITS);
        end else begin
            q <= d;
        end
    end

    assign mem_req  = q.req;
    assign mem_wb   = q.wb;
    assign mem_addr = q.addr;
    assign mem_data = q.data;
    assign irq      = q.irq;
    assign busy     = (q.cred != CRED_W'(CREDITS));
    assign rptr     = q.rptr;
    assign wptr     = q.wptr;
    assign ovf      = q.ovf;
    assign cred     = q.cred;

endmodule

// File: rtl/ivr_writer.sv
module ivr_writer
    import ivr_pkg::*;
#(
    parameter int MAX_LOG2W = 14,
    parameter int CREDITS   = 16,
    localparam int PTR_W    = MAX_LOG2W + 2,
    localparam int CRED_W   = $clog2(CREDITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_valid,
    output logic          ev_ready,
    input  logic [7:0]    ev_src,
    input  logic [27:0]   ev_data,
    input  logic [7:0]    ev_ring,
    input  logic [7:0]    ev_vm,
    input  logic [15:0]   ev_pasid,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic          mem_wb,
    output logic [39:0]   mem_addr,
    output logic [127:0]  mem_data,
    input  logic          mem_done,
    output logic          irq,
    output logic          busy
);

    cfg_t              cfg;
    logic [31:0]       base;
    logic [ADDR_W-1:0] wb_addr;
    logic              ovf_clr, rptr_wr, wptr_wr;
    logic [PTR_W-1:0]  rptr, wptr;
    logic              ovf;
    logic [CRED_W-1:0] cred;
    logic [VEC_W-1:0]  vec;

    assign vec = {32'h0, ev_pasid, ev_vm, ev_ring, 4'h0, ev_data, 24'h0, ev_src};

    ivr_regs #(.DEF_LOG2W(MAX_LOG2W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .cfg(cfg), .base(base), .wb_addr(wb_addr),
        .ovf_clr(ovf_clr), .rptr_wr(rptr_wr), .wptr_wr(wptr_wr)
    );

    ivr_ring #(.MAX_LOG2W(MAX_LOG2W), .PTR_W(PTR_W), .CREDITS(CREDITS), .CRED_W(CRED_W)) u_ring (
        .clk(clk), .rst_n(rst_n),
        .cfg(cfg), .base(base), .wb_addr(wb_addr),
        .ovf_clr(ovf_clr), .rptr_wr(rptr_wr), .wptr_wr(wptr_wr),
        .ptr_wdata(reg_wdata[PTR_W-1:0]),
        .ev_valid(ev_valid), .vec(vec), .mem_done(mem_done),
        .ev_ready(ev_ready), .mem_req(mem_req), .mem_wb(mem_wb),
        .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq), .busy(busy),
        .rptr(rptr), .wptr(wptr), .ovf(ovf), .cred(cred)
    );

    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = {19'h0, cfg.log2w, 3'h0, cfg.rearm, cfg.wb_en,
                                  cfg.ovf_det, cfg.irq_en, cfg.ring_en};
            A_BASE:  reg_rdata = base;
            A_WBLO:  reg_rdata = wb_addr[31:0];
            A_WBHI:  reg_rdata = {24'h0, wb_addr[39:32]};
            A_RPTR:  reg_rdata = 32'(rptr);
            A_WPTR:  reg_rdata = 32'(wptr) | 32'(ovf);
            default: reg_rdata = 32'h0;
        endcase
    end

endmodule

// File: rtl/ivr_checker.sv
module ivr_checker #(
    parameter int CREDITS = 16,
    parameter int CRED_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_valid,
    input logic              ev_ready,
    input logic              mem_req,
    input logic              mem_wb,
    input logic [3:0]        addr_lo,
    input logic              busy,
    input logic              irq,
    input logic              ring_en,
    input logic              irq_en,
    input logic              ovf,
    input logic              ovf_clr,
    input logic [CRED_W-1:0] cred
);

    // R2: vector writes land on 16-byte slots
    a_r2_vec_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_wb) |-> (addr_lo == 4'h0));

    // R4: the overflow flag only drops on a clear strobe
    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    // R6: a writeback request always directly follows a vector request
    a_r6_wb_after_vec: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_wb) |-> $past(mem_req && !mem_wb));

    // R7: no interrupt unless interrupts were enabled
    a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(irq_en));

    // R9: no acceptance while the ring is disabled
    a_r9_no_accept_off: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready) |-> ring_en);

    // R10: a request holds a credit, and credits never exceed the pool
    a_r10_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    a_r10_cred_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cred <= CRED_W'(CREDITS));

endmodule

bind ivr_writer ivr_checker #(.CREDITS(CREDITS), .CRED_W(CRED_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .mem_req(mem_req), .mem_wb(mem_wb), .addr_lo(mem_addr[3:0]),
    .busy(busy), .irq(irq), .ring_en(cfg.ring_en), .irq_en(cfg.irq_en),
    .ovf(ovf), .ovf_clr(ovf_clr), .cred(cred)
);

// File: tb/sim_ivr_writer.sv
module sim_ivr_writer;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ev_valid = 1'b0;
    logic         ev_ready;
    logic [7:0]   ev_src = '0;
    logic [27:0]  ev_data = '0;
    logic [7:0]   ev_ring = '0;
    logic [7:0]   ev_vm = '0;
    logic [15:0]  ev_pasid = '0;
    logic         reg_wr = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         mem_req, mem_wb, irq, busy;
    logic [39:0]  mem_addr;
    logic [127:0] mem_data;
    logic         mem_done = 1'b0;

    int nchk = 0;
    int nerr = 0;
    bit fin = 0;
    bit hold = 0;
    int owed = 0;

    logic         c_req, c_wb, c_irq, c_rdy, c2_req, c2_wb, c2_irq;
    logic [39:0]  c_addr, c2_addr;
    logic [127:0] c_data, c2_data;

    always #5 clk = ~clk;

    ivr_writer u0 (.*);

    // memory model: one completion per cycle unless held
    always @(negedge clk) begin
        if (!rst_n) begin
            owed = 0;
            mem_done = 1'b0;
        end else begin
            if (mem_req) owed++;
            if (!hold && owed > 0) begin
                mem_done = 1'b1;
                owed--;
            end else begin
                mem_done = 1'b0;
            end
        end
    end

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    function automatic logic [31:0] ctl(input bit en, ie, od, wb, ra, clr, input int lg);
        return (32'(lg) << 8) | (32'(clr) << 5) | (32'(ra) << 4) | (32'(wb) << 3)
             | (32'(od) << 2) | (32'(ie) << 1) | 32'(en);
    endfunction

    function automatic logic [127:0] expv(input logic [7:0] s, input logic [27:0] d,
                                          input logic [7:0] r, v, input logic [15:0] p);
        logic [127:0] e;
        e = '0;
        e[7:0] = s; e[59:32] = d; e[71:64] = r; e[79:72] = v; e[95:80] = p;
        return e;
    endfunction

    task automatic send(input logic [7:0] s, input logic [27:0] d,
                        input logic [7:0] r, v, input logic [15:0] p);
        ev_src = s; ev_data = d; ev_ring = r; ev_vm = v; ev_pasid = p;
        ev_valid = 1'b1;
        for (int w = 0; w < 100 && !ev_ready; w++) @(negedge clk);
        @(negedge clk);
        ev_valid = 1'b0;
        c_req = mem_req; c_wb = mem_wb; c_addr = mem_addr; c_data = mem_data;
        c_irq = irq; c_rdy = ev_ready;
        @(negedge clk);
        c2_req = mem_req; c2_wb = mem_wb; c2_addr = mem_addr; c2_data = mem_data;
        c2_irq = irq;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!fin) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] base;
        logic [39:0] bb;
        base = 32'h0012_3456;
        bb = {base, 8'h00};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, v); check("R1 ctrl", v, 32'h0000_0E00);
        rd(3'd4, v); check("R1 rptr", v, 0);
        rd(3'd5, v); check("R1 wptr", v, 0);
        check("R1 irq", irq, 0);
        check("R1 busy", busy, 0);
        check("R1 mem_req", mem_req, 0);
        check("R1 ev_ready", ev_ready, 0);

        wr(3'd1, base);

        // R2 R3 R7: sweep of ring sizes with wrap, software keeping up
        for (int lg = 3; lg <= 6; lg++) begin
            int bytes;
            int n;
            bytes = 4 << lg;
            n = bytes / 16;
            wr(3'd0, ctl(1, 1, 0, 0, 0, 0, lg));
            wr(3'd4, 0);
            wr(3'd5, 0);
            for (int i = 0; i < 2 * n; i++) begin
                logic [7:0] s; logic [27:0] d; logic [7:0] r, vm; logic [15:0] p;
                s = 8'(i * 7 + lg); d = 28'(i * 32'h0123_457 + 5); r = 8'(i + 1);
                vm = 8'(255 - i); p = 16'(i * 16'h1111 + lg);
                send(s, d, r, vm, p);
                check("R2 req", c_req, 1);
                check("R2 kind", c_wb, 0);
                check("R3 addr wrap", c_addr, bb + 40'((16 * i) % bytes));
                check("R2 data", c_data, expv(s, d, r, vm, p));
                check("R7 irq on vector", c_irq, 1);
                check("R7 irq one cycle", c2_irq, 0);
                rd(3'd5, v); check("R3 wptr", v, 32'((16 * (i + 1)) % bytes));
                wr(3'd4, v);
            end
        end

        // R3 pointer write masking (lg=4 => 64 bytes)
        wr(3'd0, ctl(1, 1, 0, 0, 0, 0, 4));
        wr(3'd5, 32'h0000_01F7);
        rd(3'd5, v); check("R3 wptr masked", v, 32'h30);
        wr(3'd4, 32'h0000_0055);
        rd(3'd4, v); check("R3 rptr masked", v, 32'h10);

        // R4 overflow on a 4-entry ring
        wr(3'd0, ctl(1, 1, 1, 0, 0, 0, 4));
        wr(3'd4, 0);
        wr(3'd5, 0);
        for (int i = 0; i < 3; i++) send(8'(i), 28'h1, 8'h0, 8'h0, 16'h0);
        rd(3'd5, v); check("R4 no flag when one short", v, 32'h30);
        send(8'h44, 28'h2, 8'h0, 8'h0, 16'h0);
        check("R4 overflow vector still written", c_addr, bb + 40'h30);
        rd(3'd5, v); check("R4 flag set", v, 32'h01);
        send(8'h45, 28'h3, 8'h0, 8'h0, 16'h0);
        rd(3'd5, v); check("R4 flag sticky", v, 32'h11);
        // R5 clear strobe
        wr(3'd0, ctl(1, 1, 1, 0, 0, 1, 4));
        rd(3'd5, v); check("R5 flag cleared", v, 32'h10);
        rd(3'd0, v); check("R5 ctrl kept", v, ctl(1, 1, 1, 0, 0, 0, 4));
        // R4 detection off
        wr(3'd0, ctl(1, 1, 0, 0, 0, 0, 4));
        wr(3'd4, 0);
        wr(3'd5, 0);
        for (int i = 0; i < 5; i++) send(8'(i), 28'h1, 8'h0, 8'h0, 16'h0);
        rd(3'd5, v); check("R4 no flag with detection off", v, 32'h10);

        // R6 writeback
        wr(3'd0, ctl(1, 1, 0, 1, 0, 0, 14));
        wr(3'd2, 32'h1000_0040);
        wr(3'd3, 32'h0000_005A);
        wr(3'd4, 0);
        wr(3'd5, 32'h20);
        send(8'h9, 28'hABCDEF1, 8'h2, 8'h3, 16'hBEEF);
        check("R6 vector addr", c_addr, bb + 40'h20);
        check("R6 vector kind", c_wb, 0);
        check("R7 no irq on vector when wb", c_irq, 0);
        check("R6 ready low during wb", c_rdy, 0);
        check("R6 wb req", c2_req, 1);
        check("R6 wb kind", c2_wb, 1);
        check("R6 wb addr", c2_addr, 40'h5A_1000_0040);
        check("R6 wb data", c2_data, 128'h30);
        check("R7 irq on wb", c2_irq, 1);

        // R7 interrupt enable off
        wr(3'd0, ctl(1, 0, 0, 0, 0, 0, 14));
        send(8'h1, 28'h1, 8'h1, 8'h1, 16'h1);
        check("R7 req with irq off", c_req, 1);
        check("R7 no irq when disabled", c_irq, 0);

        // R8 re-arm (wptr now 0x40)
        wr(3'd0, ctl(1, 1, 0, 0, 1, 0, 14));
        wr(3'd4, 32'h10);
        check("R8 rearm pulse", irq, 1);
        wr(3'd4, 32'h40);
        check("R8 no pulse when equal", irq, 0);
        wr(3'd0, ctl(1, 1, 0, 0, 0, 0, 14));
        wr(3'd4, 32'h10);
        check("R8 no pulse without rearm", irq, 0);

        // R9 ring disabled
        wr(3'd0, ctl(0, 1, 0, 0, 0, 0, 14));
        ev_valid = 1'b1;
        begin
            int reqs;
            reqs = 0;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                if (mem_req) reqs++;
                check("R9 ready low", ev_ready, 0);
            end
            check("R9 no requests", reqs, 0);
        end
        ev_valid = 1'b0;
        rd(3'd5, v); check("R9 wptr unchanged", v, 32'h40);

        // R10 credits
        wr(3'd0, ctl(1, 0, 0, 0, 0, 0, 14));
        wr(3'd4, 0);
        wr(3'd5, 0);
        hold = 1;
        for (int i = 0; i < 16; i++) send(8'(i), 28'h0, 8'h0, 8'h0, 16'h0);
        check("R10 busy", busy, 1);
        check("R10 no credit stall", ev_ready, 0);
        ev_valid = 1'b1;
        begin
            int reqs;
            reqs = 0;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                if (mem_req) reqs++;
            end
            check("R10 no request without credit", reqs, 0);
        end
        ev_valid = 1'b0;
        rd(3'd5, v); check("R10 wptr after stall", v, 32'h100);
        hold = 0;
        repeat (20) @(negedge clk);
        check("R10 idle after completions", busy, 0);
        check("R10 ready restored", ev_ready, 1);

        fin = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

endmodule